// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers one non-maskable request and a bank of sixteen maskable peripheral request lines and turns them into a single pending signal for a CPU core. The non-maskable input is active low. It is captured on its falling edge into a latch, and that latch beats every other source, whatever the masks hold. The maskable lines are level requests. Each one is qualified by its own bit in a mask register and by a global enable input. Among the maskable lines that qualify, the lowest-numbered line wins.

The CPU sees `pend_o`, answers with a one-cycle acknowledge, and then reads the captured vector number through a small register port. Vector 1 stands for the non-maskable source. Maskable line n produces vector 16 + n. Vector 0 means nothing was pending at the acknowledge. Lines 0, 3, 7 and 15 are reserved: their enable bits cannot be set, so their vectors are never produced. When the acknowledge captures vector 1, it also clears the non-maskable latch.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A high-to-low transition on `nmi_n_i`, seen between two consecutive rising clock edges, sets the non-maskable latch at the second of those edges. A steady low level and a rising transition set nothing.
- R2: While the non-maskable latch is set, `pend_o` is 1 and an acknowledge captures vector 1, regardless of `gie_i`, the mask register and the request lines.
- R3: When maskable line n is the winning source, an acknowledge captures vector 16 + n.
- R4: Among maskable lines that are requesting and enabled, the line with the lowest index wins.
- R5: Register address 0 is the 16-bit mask register, where bit n enables line n. A write stores the write data with bits 0, 3, 7 and 15 forced to 0, and these bits always read as 0. A request on lines 0, 3, 7 or 15 never raises `pend_o` and never yields vectors 16, 19, 23 or 31.
- R6: While `gie_i` is 0, maskable requests neither raise `pend_o` nor get captured. An acknowledge with no pending source captures vector 0.
- R7: Register address 1 reads the vector register, zero-extended to 16 bits. The register loads only on a cycle with `ack_i` = 1 and keeps its value until the next acknowledge, even if the requests change in between.
- R8: An acknowledge that captures vector 1 clears the non-maskable latch. Further falling edges that arrive before that acknowledge merge into the same event. A falling edge in the acknowledge cycle itself keeps the latch set.
- R9: After reset, `pend_o` is 0, the mask register reads 0, the vector register reads 0, and `nmi_n_i` counts as having been high.
- R10: Maskable requests are levels. `pend_o` follows a request line in the same cycle, with no register in the path, and an acknowledge does not clear a maskable request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_n_i | input | 1 | Non-maskable request, active low, edge detected |
| irq_i | input | 16 | Maskable request levels, line n on bit n |
| gie_i | input | 1 | Global enable for the maskable lines |
| ack_i | input | 1 | Acknowledge from the CPU; captures the vector |
| reg_addr_i | input | 1 | Register select: 0 = mask, 1 = vector |
| reg_wr_i | input | 1 | Write strobe (the mask register is the only writable register) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register, combinational |
| pend_o | output | 1 | An interrupt is pending |

## Verification
- **Combinational paths:** `pend_o` and `reg_rdata_o` have no register in their path. The bench samples them 1 ns after it drives the inputs on the falling clock edge.
- **Register state:** the vector register, the mask register and the non-maskable latch update on the next rising edge. Each check of them waits until the following falling edge.
- **Non-maskable edge:** `nmi_n_i` is driven low on a falling edge. The latch is expected set half a cycle later, after one rising edge.
- **Clearing the latch:** an acknowledge held across one rising edge must both load vector 1 and drop `pend_o`. The bench checks both effects at the next falling edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_LINES  = 16;
    localparam int LINE_BASE  = 16;
    localparam int NMI_VEC    = 1;
    localparam int VEC_W      = $clog2(LINE_BASE + NUM_LINES);
    localparam int REG_W      = 16;
    localparam logic [NUM_LINES-1:0] RSVD_LINES = 16'h8089;

    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        logic prev;
        logic latch;
    } nmi_state_t;
endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n_i,
    input  logic clr_i,
    output logic latch_o
);
    import irq_pkg::*;

    nmi_state_t s_d, s_q;
    logic       fall;

    always_comb begin
        s_d       = s_q;
        fall      = s_q.prev & ~nmi_n_i;
        s_d.prev  = nmi_n_i;
        // a new edge in the clearing cycle keeps the latch set
        s_d.latch = fall | (s_q.latch & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.prev  <= 1'b1;
            s_q.latch <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign latch_o = s_q.latch;

    assert_fall_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> latch_o);
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !latch_o) |=> !latch_o);
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !fall) |=> !latch_o);
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int N = irq_pkg::NUM_LINES,
    parameter logic [N-1:0] RSVD = irq_pkg::RSVD_LINES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] mask_o
);
    logic [N-1:0] mask_d, mask_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (RSVD[i]) begin : g_rsvd
            assign mask_d[i] = 1'b0;
        end else begin : g_live
            assign mask_d[i] = wr_i ? wdata_i[i] : mask_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask_o = mask_q;

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
    parameter int N     = irq_pkg::NUM_LINES,
    parameter int BASE  = irq_pkg::LINE_BASE,
    parameter int VEC_W = irq_pkg::VEC_W
) (
    input  logic [N-1:0]     req_i,
    output logic             valid_o,
    output logic [VEC_W-1:0] vec_o
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx = '0;
        // scan from the top so the lowest index is written last
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx = IDX_W'(i);
        end
        valid_o = |req_i;
        vec_o   = VEC_W'(BASE) + VEC_W'(idx);
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter int N     = irq_pkg::NUM_LINES,
    parameter int BASE  = irq_pkg::LINE_BASE,
    parameter int NMIV  = irq_pkg::NMI_VEC,
    parameter int REG_W = irq_pkg::REG_W,
    parameter logic [N-1:0] RSVD = irq_pkg::RSVD_LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_n_i,
    input  logic [N-1:0]     irq_i,
    input  logic             gie_i,
    input  logic             ack_i,
    input  logic             reg_addr_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             pend_o
);
    localparam int VEC_W = $clog2(BASE + N);

    typedef struct packed {
        logic [VEC_W-1:0] vec;
    } ctl_state_t;

    ctl_state_t       st_d, st_q;
    logic             nmi_latch;
    logic             nmi_clr;
    logic [N-1:0]     mask;
    logic [N-1:0]     qual;
    logic             mi_valid;
    logic [VEC_W-1:0] mi_vec;
    logic [VEC_W-1:0] sel_vec;

    irq_nmi_edge u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_n_i (nmi_n_i),
        .clr_i   (nmi_clr),
        .latch_o (nmi_latch)
    );

    irq_mask_bank #(.N(N), .RSVD(RSVD)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i && !reg_addr_i),
        .wdata_i (reg_wdata_i[N-1:0]),
        .mask_o  (mask)
    );

    irq_prio_sel #(.N(N), .BASE(BASE), .VEC_W(VEC_W)) u_prio (
        .req_i   (qual),
        .valid_o (mi_valid),
        .vec_o   (mi_vec)
    );

    always_comb begin
        qual    = irq_i & mask & {N{gie_i}};
        sel_vec = nmi_latch ? VEC_W'(NMIV) : (mi_valid ? mi_vec : '0);
        nmi_clr = ack_i & nmi_latch;
        pend_o  = nmi_latch | mi_valid;
        st_d    = st_q;
        if (ack_i) st_d.vec = sel_vec;
        reg_rdata_o = reg_addr_i ? REG_W'(st_q.vec) : REG_W'(mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_nmi_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_latch && ack_i) |=> (st_q.vec == VEC_W'(NMIV)));
    assert_nmi_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_latch |-> pend_o);
    assert_no_reserved_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (st_q.vec == '0 || st_q.vec == VEC_W'(NMIV) ||
                   (st_q.vec >= VEC_W'(BASE) && !RSVD[st_q.vec - VEC_W'(BASE)])));
    assert_gie_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie_i && !nmi_latch) |-> !pend_o);
    assert_vec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> $stable(st_q.vec));
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_n_i = 1'b1;
    logic [15:0] irq_i = '0;
    logic        gie_i = 1'b0;
    logic        ack_i = 1'b0;
    logic        reg_addr_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        pend_o;

    int checks = 0;
    int errors = 0;
    localparam logic [15:0] RSV = 16'h8089;

    always #10 clk = ~clk;

    irq_vector_ctrl dut (
        .clk(clk), .rst_n(rst_n), .nmi_n_i(nmi_n_i), .irq_i(irq_i),
        .gie_i(gie_i), .ack_i(ack_i), .reg_addr_i(reg_addr_i),
        .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .pend_o(pend_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_vec(input logic [15:0] rq, input logic [15:0] m,
                                            input logic g, input logic nmi);
        logic [15:0] e;
        e = rq & m & ~RSV;
        if (nmi) return 16'd1;
        if (g) for (int i = 0; i < 16; i++) if (e[i]) return 16'(16 + i);
        return 16'd0;
    endfunction

    task automatic wr_mask(input logic [15:0] v);
        @(negedge clk); reg_wr_i = 1'b1; reg_addr_i = 1'b0; reg_wdata_i = v;
        @(negedge clk); reg_wr_i = 1'b0;
    endtask

    task automatic do_ack;
        @(negedge clk); ack_i = 1'b1;
        @(negedge clk); ack_i = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [15:0] v);
        reg_addr_i = a; #1; v = reg_rdata_o;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, m, rq;
        logic [31:0] lf;
        logic g;
        #45 rst_n = 1'b1;
        @(negedge clk);
        #1; chk("R9 pend", {15'd0, pend_o}, 16'd0);
        rd(1'b0, v); chk("R9 mask", v, 16'd0);
        rd(1'b1, v); chk("R9 vec", v, 16'd0);

        // mask register, reserved bits forced
        wr_mask(16'hFFFF);
        rd(1'b0, v); chk("R5 mask readback", v, 16'h7F76);

        // single-line sweep
        gie_i = 1'b1;
        for (int n = 0; n < 16; n++) begin
            @(negedge clk); irq_i = 16'(1) << n; #1;
            chk("R5 single pend", {15'd0, pend_o}, {15'd0, !RSV[n]});
            do_ack;
            rd(1'b1, v); chk("R3 single vec", v, exp_vec(irq_i, 16'hFFFF, 1'b1, 1'b0));
        end

        // global enable low
        @(negedge clk); gie_i = 1'b0; irq_i = 16'hFFFF; #1;
        chk("R6 gie low pend", {15'd0, pend_o}, 16'd0);
        do_ack; rd(1'b1, v); chk("R6 gie low vec", v, 16'd0);

        // pseudo-random priority sweep
        lf = 32'h1234_5678;
        for (int k = 0; k < 300; k++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            m = lf[15:0]; rq = lf[31:16]; g = (k % 5) != 0;
            wr_mask(m);
            @(negedge clk); irq_i = rq; gie_i = g; #1;
            chk("R4 pend", {15'd0, pend_o}, {15'd0, exp_vec(rq, m, g, 1'b0) != 0});
            do_ack; rd(1'b1, v); chk("R4 vec", v, exp_vec(rq, m, g, 1'b0));
        end

        // vector holds between acks
        wr_mask(16'hFFFF);
        @(negedge clk); gie_i = 1'b1; irq_i = 16'h0004; do_ack;
        @(negedge clk); irq_i = 16'h0002; @(negedge clk); irq_i = 16'h0000;
        rd(1'b1, v); chk("R7 hold", v, 16'd18);

        // level behaviour
        @(negedge clk); irq_i = 16'h0100; #1; chk("R10 level on", {15'd0, pend_o}, 16'd1);
        do_ack; #1; chk("R10 ack keeps", {15'd0, pend_o}, 16'd1);
        @(negedge clk); irq_i = 16'h0000; #1; chk("R10 level off", {15'd0, pend_o}, 16'd0);

        // NMI edge with everything masked
        wr_mask(16'h0000); gie_i = 1'b0;
        @(negedge clk); nmi_n_i = 1'b0;
        #1; chk("R1 before edge", {15'd0, pend_o}, 16'd0);
        @(negedge clk); #1; chk("R1 after edge", {15'd0, pend_o}, 16'd1);
        wr_mask(16'hFFFF); gie_i = 1'b1; irq_i = 16'h0002;
        do_ack; rd(1'b1, v); chk("R2 nmi vec", v, 16'd1);
        gie_i = 1'b0; #1; chk("R8 cleared", {15'd0, pend_o}, 16'd0);
        repeat (3) @(negedge clk); #1; chk("R1 low level", {15'd0, pend_o}, 16'd0);
        @(negedge clk); nmi_n_i = 1'b1;
        @(negedge clk); #1; chk("R1 rising", {15'd0, pend_o}, 16'd0);

        // two edges merged
        @(negedge clk); nmi_n_i = 1'b0; @(negedge clk); nmi_n_i = 1'b1;
        @(negedge clk); nmi_n_i = 1'b0; @(negedge clk); nmi_n_i = 1'b1;
        #1; chk("R8 merged pend", {15'd0, pend_o}, 16'd1);
        do_ack; #1; chk("R8 merged clear", {15'd0, pend_o}, 16'd0);

        // edge in the ack cycle keeps the latch
        @(negedge clk); nmi_n_i = 1'b0; @(negedge clk); nmi_n_i = 1'b1;
        @(negedge clk); ack_i = 1'b1; nmi_n_i = 1'b0;
        @(negedge clk); ack_i = 1'b0; #1;
        chk("R8 edge in ack", {15'd0, pend_o}, 16'd1);
        do_ack; #1; chk("R8 final clear", {15'd0, pend_o}, 16'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule